// File: doc/BRIEF.md
# Synchronous Serial Byte Receiver

This block takes an 8-bit byte from a serial data line one bit at a time, least significant bit first, and places it in a buffer that the host reads. The bit clock comes from one of two places. In internal mode the block makes the clock itself by dividing the system clock, and drives it out to the sending device. In external mode the sending device supplies the clock, and the block samples the data on its rising edges after passing both lines through a two-flop synchroniser.

A host turns reception on by raising the run bit while the receive-mode enable is set. Each finished byte raises the buffer-full request until the host reads the buffer. In internal mode the clock stops, held high, while an unread byte sits in the buffer, so no data can be lost. In external mode the clock cannot be held back, and a newer byte overwrites the older one. There are two ways to stop. Lowering the run bit lets the byte in progress finish. Raising the inhibit bit ends reception at once and throws away the partial byte. The busy flag shows when reception has really ended.

Top module: `sio_rx_unit`

## Requirements
- R1: After reset, busy_o, buf_full_o and buf_data_o are 0, sck_o is 1, and sck_oe_o equals the inverse of ext_clk_i.
- R2: busy_o rises one cycle after a clock edge at which run_i=1, rx_mode_i=1, inhibit_i=0 and the unit is idle.
- R3: Bits are assembled least significant bit first. The first sampled bit lands in buf_data_o[0] and the eighth in buf_data_o[7].
- R4: The edge that samples the eighth bit writes the byte to buf_data_o and sets buf_full_o. A one-cycle rd_i pulse clears buf_full_o on the next edge, unless a byte completes on that same edge.
- R5: In internal mode, sck_o idles high. It runs with a period of DIV system clocks, made of high and low halves of DIV/2 clocks each. Data is sampled on its rising edge, and sck_oe_o is 1.
- R6: In internal mode, while buf_full_o is 1, sck_o stays high and no bits are taken. Clocking resumes after the buffer is read.
- R7: In external mode, sck_i and sd_i pass through two synchroniser flops. A bit is taken on each detected rising edge of sck_i, sck_oe_o is 0, and a byte that completes while the buffer is full overwrites it and keeps buf_full_o set.
- R8: If run_i is low while the byte in progress has no bits yet, busy_o clears on the next edge. If run_i goes low mid-byte, the byte completes and is written, and busy_o clears one edge after that write.
- R9: inhibit_i=1 (with rx_mode_i=1) clears busy_o on the next edge and forces sck_o high. The partial byte is dropped, with no buffer write and no buffer-full request.
- R10: rx_mode_i=0 returns the unit to idle, clears buf_data_o to 0 and clears buf_full_o on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_mode_i | input | 1 | Receive mode enable; 0 clears the buffer |
| run_i | input | 1 | Run bit; level starts reception, low requests a graceful stop |
| inhibit_i | input | 1 | Immediate abort |
| ext_clk_i | input | 1 | Clock source select: 1 external, 0 internal |
| rd_i | input | 1 | One-cycle buffer read strobe |
| sck_i | input | 1 | External serial clock |
| sd_i | input | 1 | Serial data in |
| sck_o | output | 1 | Internally generated serial clock |
| sck_oe_o | output | 1 | Output enable for sck_o (internal mode) |
| busy_o | output | 1 | Reception active |
| buf_full_o | output | 1 | Buffer-full interrupt request |
| buf_data_o | output | DATA_W | Received byte buffer |

## Verification
A bad bit counter or shift register shows up as a wrong buf_data_o, or as buf_full_o rising on the wrong edge, within one byte time. A bad divider or stall condition shows up in sck_o within a half period, either as a clock that moves while buf_full_o is set or as an edge at the wrong cycle. A busy state that is out of step with the stop and abort rules shows on busy_o on the edge right after run_i or inhibit_i changes. The reference model predicts every output on every cycle, so each of these faults is caught on the cycle it first reaches a port.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RUN  = 1'b1
    } rx_state_e;

    localparam int RX_BYTE_W = 8;

endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o
);

    localparam int CHAIN = STAGES + 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [CHAIN-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[CHAIN-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
        assign rise_o[b] = chain_q[STAGES-1] & ~chain_q[STAGES];

        // R7
        single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[b] |=> !rise_o[b]);
    end

endmodule

// File: rtl/sio_rx_clkgen.sv
module sio_rx_clkgen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sck_o,
    output logic rise_o
);

    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sck;
    } gen_t;

    gen_t q, d;

    always_comb begin
        d = q;
        if (!en_i) begin
            d.cnt = '0;
            d.sck = 1'b1;
        end else if (q.cnt == LAST) begin
            d.cnt = '0;
            d.sck = ~q.sck;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, sck: 1'b1};
        else        q <= d;
    end

    assign sck_o  = q.sck;
    assign rise_o = en_i && (q.cnt == LAST) && !q.sck;

    // R5
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> sck_o);

    // R5
    half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LAST);

endmodule

// File: rtl/sio_rx_shift.sv
module sio_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o,
    output logic         last_o,
    output logic         empty_o
);

    localparam int CNTW = $clog2(W);
    localparam logic [CNTW-1:0] TOP = CNTW'(W - 1);

    typedef struct packed {
        logic [W-1:0]    sh;
        logic [CNTW-1:0] cnt;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.sh  = '0;
            d.cnt = '0;
        end else if (en_i) begin
            d.sh  = {bit_i, q.sh[W-1:1]};
            d.cnt = (q.cnt == TOP) ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_o  = {bit_i, q.sh[W-1:1]};
    assign last_o  = (q.cnt == TOP);
    assign empty_o = (q.cnt == '0);

    // R9
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> empty_o);

endmodule

// File: rtl/sio_rx_unit.sv
module sio_rx_unit #(
    parameter int DATA_W      = sio_rx_pkg::RX_BYTE_W,
    parameter int DIV         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_mode_i,
    input  logic              run_i,
    input  logic              inhibit_i,
    input  logic              ext_clk_i,
    input  logic              rd_i,
    input  logic              sck_i,
    input  logic              sd_i,
    output logic              sck_o,
    output logic              sck_oe_o,
    output logic              busy_o,
    output logic              buf_full_o,
    output logic [DATA_W-1:0] buf_data_o
);

    import sio_rx_pkg::*;

    typedef struct packed {
        rx_state_e         st;
        logic [DATA_W-1:0] data;
        logic              full;
    } ctl_t;

    ctl_t q, d;

    logic [1:0]        pin_sync, pin_rise;
    logic              int_rise, sck_int;
    logic [DATA_W-1:0] word;
    logic              last_bit, no_bits;
    logic              keep_going, gen_en, take, shf_clr;

    sio_rx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sd_i, sck_i}),
        .sync_o  (pin_sync),
        .rise_o  (pin_rise)
    );

    always_comb begin
        keep_going = (q.st == RX_RUN) && rx_mode_i && !inhibit_i
                     && !(no_bits && !run_i);
        gen_en     = keep_going && !ext_clk_i && !q.full;
        take       = keep_going && (ext_clk_i ? pin_rise[0] : int_rise);
        shf_clr    = !keep_going;
    end

    sio_rx_clkgen #(.DIV(DIV)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (gen_en),
        .sck_o  (sck_int),
        .rise_o (int_rise)
    );

    sio_rx_shift #(.W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (shf_clr),
        .en_i    (take),
        .bit_i   (pin_sync[1]),
        .word_o  (word),
        .last_o  (last_bit),
        .empty_o (no_bits)
    );

    always_comb begin
        d      = q;
        d.full = q.full && !rd_i;
        if (!rx_mode_i) begin
            d.st   = RX_IDLE;
            d.data = '0;
            d.full = 1'b0;
        end else if (inhibit_i) begin
            d.st = RX_IDLE;
        end else if (q.st == RX_IDLE) begin
            if (run_i) d.st = RX_RUN;
        end else if (!keep_going) begin
            d.st = RX_IDLE;
        end else if (take && last_bit) begin
            d.data = word;
            d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RX_IDLE, data: '0, full: 1'b0};
        else        q <= d;
    end

    assign sck_o      = sck_int;
    assign sck_oe_o   = !ext_clk_i;
    assign busy_o     = (q.st == RX_RUN);
    assign buf_full_o = q.full;
    assign buf_data_o = q.data;

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode_i && run_i && !inhibit_i && !busy_o) |=> busy_o);

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode_i && inhibit_i) |=> (!busy_o && sck_o));

    // R6
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full_o |-> sck_o);

    // R5
    idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> sck_o);

    // R10
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_mode_i |=> (!busy_o && !buf_full_o && buf_data_o == '0));

    // R4
    full_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full_o) |-> $past(busy_o));

    // R8
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode_i && !busy_o) |=> $stable(buf_data_o));

endmodule

// File: tb/sio_rx_unit_bench.sv
module sio_rx_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW  = 8;
    localparam int DIV = 8;
    localparam int HALF = DIV / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_mode = 1'b0, run = 1'b0, inhibit = 1'b0, ext_sel = 1'b0, rd = 1'b0;
    logic sck_ext = 1'b1, sd_ext = 1'b0, sd_int = 1'b0;
    logic sd;
    logic sck_o, sck_oe_o, busy_o, buf_full_o;
    logic [DW-1:0] buf_data_o;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    logic [DW-1:0] tx_byte = 8'h00;
    int pidx = 0;
    logic last_sck = 1'b1;
    bit done = 0;

    assign sd = ext_sel ? sd_ext : sd_int;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_rx_unit #(.DATA_W(DW), .DIV(DIV), .SYNC_STAGES(2)) u_sio_rx_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_mode_i  (rx_mode),
        .run_i      (run),
        .inhibit_i  (inhibit),
        .ext_clk_i  (ext_sel),
        .rd_i       (rd),
        .sck_i      (sck_ext),
        .sd_i       (sd),
        .sck_o      (sck_o),
        .sck_oe_o   (sck_oe_o),
        .busy_o     (busy_o),
        .buf_full_o (buf_full_o),
        .buf_data_o (buf_data_o)
    );

    // Sending partner for internal mode: new bit after each falling sck_o.
    always @(negedge clk) begin
        if (!ext_sel && last_sck && !sck_o) begin
            sd_int <= tx_byte[pidx];
            pidx   <= (pidx + 1) % DW;
        end
        last_sck <= sck_o;
    end

    // Behavioural reference model
    int m_s1, m_s2, m_s3, m_d1, m_d2;
    int m_busy, m_bits, m_acc, m_buf, m_full, m_sck, m_cnt;

    task automatic model_step();
        int rise, b, nfull, takeit;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_d1 = 0; m_d2 = 0;
            m_busy = 0; m_bits = 0; m_acc = 0; m_buf = 0; m_full = 0;
            m_sck = 1; m_cnt = 0;
            return;
        end
        rise = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
        b = m_d2;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(sck_ext);
        m_d2 = m_d1; m_d1 = int'(sd);
        if (!rx_mode) begin
            m_busy = 0; m_bits = 0; m_acc = 0; m_cnt = 0; m_sck = 1;
            m_buf = 0; m_full = 0;
        end else if (inhibit) begin
            m_busy = 0; m_bits = 0; m_acc = 0; m_cnt = 0; m_sck = 1;
            if (rd) m_full = 0;
        end else if (m_busy == 0) begin
            if (rd) m_full = 0;
            m_cnt = 0; m_sck = 1; m_bits = 0; m_acc = 0;
            if (run) m_busy = 1;
        end else begin
            nfull = (m_full != 0 && !rd) ? 1 : 0;
            if (m_bits == 0 && !run) begin
                m_busy = 0; m_cnt = 0; m_sck = 1; m_acc = 0;
            end else begin
                takeit = 0;
                if (ext_sel) begin
                    takeit = rise; m_cnt = 0; m_sck = 1;
                end else if (m_full != 0) begin
                    m_cnt = 0; m_sck = 1;
                end else if (m_cnt == HALF - 1) begin
                    m_cnt = 0;
                    takeit = (m_sck == 0) ? 1 : 0;
                    m_sck = 1 - m_sck;
                end else begin
                    m_cnt = m_cnt + 1;
                end
                if (takeit != 0) begin
                    m_acc = (m_acc >> 1) | (b << (DW - 1));
                    m_bits = m_bits + 1;
                    if (m_bits == DW) begin
                        m_buf = m_acc; nfull = 1; m_bits = 0;
                    end
                end
            end
            m_full = nfull;
        end
    endtask

    task automatic cmp1(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always begin
        @(posedge clk);
        model_step();
        #(CLK_PERIOD/4);
        if (!done) begin
            cmp1("busy_o", int'(busy_o), m_busy);
            cmp1("buf_full_o", int'(buf_full_o), m_full);
            cmp1("buf_data_o", int'(buf_data_o), m_buf);
            cmp1("sck_o", int'(sck_o), m_sck);
            cmp1("sck_oe_o", int'(sck_oe_o), ext_sel ? 0 : 1);
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic wait_full(string req, int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (buf_full_o) return;
        end
        chk(req, "buf_full_o timeout", 0, 1);
    endtask

    task automatic do_read();
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic wait_fall(output int cycles);
        logic p;
        cycles = 0;
        p = sck_o;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            cycles++;
            if (p && !sck_o) return;
            p = sck_o;
        end
    endtask

    task automatic ext_bit(logic b);
        sd_ext = b; sck_ext = 1'b0;
        repeat (3) @(negedge clk);
        sck_ext = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic ext_byte(logic [DW-1:0] v);
        for (int i = 0; i < DW; i++) ext_bit(v[i]);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        int per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy_o", int'(busy_o), 0);
        chk("R1", "buf_full_o", int'(buf_full_o), 0);
        chk("R1", "sck_o", int'(sck_o), 1);

        // R2 / R3 / R4 internal clock byte
        cur_req = "R3";
        tx_byte = 8'hA5;
        rx_mode = 1'b1; run = 1'b1;
        @(negedge clk);
        chk("R2", "busy_o after start", int'(busy_o), 1);
        wait_full("R4", 300);
        chk("R3", "byte A5", int'(buf_data_o), 8'hA5);
        chk("R4", "full set", int'(buf_full_o), 1);

        // R6 stall while unread
        cur_req = "R6";
        repeat (40) @(negedge clk);
        chk("R6", "sck held high", int'(sck_o), 1);
        chk("R6", "still busy", int'(busy_o), 1);
        tx_byte = 8'h3C;
        do_read();
        chk("R4", "full cleared by read", int'(buf_full_o), 0);
        wait_full("R6", 300);
        chk("R6", "byte after resume", int'(buf_data_o), 8'h3C);

        // R8 graceful stop mid-byte
        cur_req = "R8";
        tx_byte = 8'h96;
        do_read();
        repeat (30) @(negedge clk);
        chk("R8", "busy mid-byte", int'(busy_o), 1);
        run = 1'b0;
        wait_full("R8", 300);
        chk("R8", "finished byte", int'(buf_data_o), 8'h96);
        repeat (2) @(negedge clk);
        chk("R8", "idle after finish", int'(busy_o), 0);

        // R5 clock period
        cur_req = "R5";
        tx_byte = 8'h81;
        do_read();
        run = 1'b1;
        wait_fall(per);
        wait_fall(per);
        chk("R5", "sck period", per, DIV);
        chk("R5", "sck_oe_o internal", int'(sck_oe_o), 1);
        wait_full("R5", 300);
        chk("R5", "byte 81", int'(buf_data_o), 8'h81);

        // R9 abort
        cur_req = "R9";
        tx_byte = 8'hFF;
        do_read();
        repeat (25) @(negedge clk);
        inhibit = 1'b1; run = 1'b0;
        @(negedge clk);
        inhibit = 1'b0;
        chk("R9", "busy cleared", int'(busy_o), 0);
        chk("R9", "sck high", int'(sck_o), 1);
        repeat (80) @(negedge clk);
        chk("R9", "no full", int'(buf_full_o), 0);
        chk("R9", "buffer untouched", int'(buf_data_o), 8'h81);

        // R7 external clock
        cur_req = "R7";
        ext_sel = 1'b1; run = 1'b1;
        repeat (3) @(negedge clk);
        ext_byte(8'h5A);
        chk("R7", "ext byte 5A", int'(buf_data_o), 8'h5A);
        chk("R7", "full", int'(buf_full_o), 1);
        chk("R7", "sck_oe_o external", int'(sck_oe_o), 0);
        ext_byte(8'hC3);
        chk("R7", "overwrite C3", int'(buf_data_o), 8'hC3);
        chk("R7", "full kept", int'(buf_full_o), 1);

        // R8 stop at byte boundary
        cur_req = "R8";
        run = 1'b0;
        @(negedge clk);
        chk("R8", "boundary stop", int'(busy_o), 0);

        // R10 mode change clears buffer
        cur_req = "R10";
        rx_mode = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", "data cleared", int'(buf_data_o), 0);
        chk("R10", "full cleared", int'(buf_full_o), 0);
        repeat (2) @(negedge clk);
        summary();
    end

endmodule